// File: doc/BRIEF.md
# External Bus Cycle Sequencer

This block turns single access requests from an 8-bit controller core into the strobe and address/data sequence of a multiplexed external bus with a 16-bit address space. An instruction fetch takes one half of a 12-period machine cycle, which is six oscillator periods. An external data read or write takes the whole 12 periods, and during that time no fetch is issued. Every strobe edge falls on an oscillator-period boundary. The oscillator period is derived inside the block from the system clock by a parameterised divider, and that period is exported as a one-clock enable.

The core issues a request with a kind, a 16-bit address, a write byte and an 8-bit-indirect flag. It holds the request until the block accepts it. The block drives the address latch strobe, the active-low program, read and write strobes, the low address/data byte with its drive enable, and the high address byte. It decides whether a fetch is served by the internal program store or by the external bus, using the external-access input and the program address. When the access ends, it returns the fetched or read byte with a one-clock completion pulse.

Top module: `ext_bus_seq`

## Requirements
- R1: Each oscillator period lasts OSC_DIV clocks, and `osc_tick_o` is high on the last clock of each period. A request is accepted only on a clock where `osc_tick_o`, `req_valid_i` and `req_ready_o` are all high, and that clock edge starts period 0. A fetch occupies periods 0 to 5, and every other kind occupies periods 0 to 11.
- R2: During an external access, `ale_o` is high in periods 0 and 1. It is low at all other times, and it is never high together with any active-low strobe.
- R3: During an external access, the low address byte is driven with `ad_oe_o` high in periods 1 and 2.
- R4: `psen_n_o` is low only in periods 3 to 5 of an external fetch. It stays high for every data access.
- R5: An external fetch returns the value present on `ad_i` in period 5. A read returns the value present on `ad_i` in period 10. Values present in any other period have no effect on the result.
- R6: Kind encoding: 0 is fetch, 1 is read, 2 is write, and 3 is a full-length data cycle with no strobe. A read drives `rd_n_o` low in periods 5 to 10. A write drives `wr_n_o` low in periods 5 to 10. At most one active-low strobe is low at any time.
- R7: During a write, the data byte is driven with `ad_oe_o` high in periods 4 to 11, and it stays unchanged while `wr_n_o` is low.
- R8: `addr_hi_o` carries the upper address byte for fetches. For data accesses with `req_short_i` high it carries `p2_latch_i`, and for other data accesses it carries the upper address byte. The value is held for the whole access.
- R9: When `ea_i` is high and the fetch address is below INT_ROM_BYTES, the fetch is internal. No strobe pulses, the bus floats, `rom_addr_o` carries the address, and `rom_data_i` is taken in period 5. When `ea_i` is low, every fetch is external.
- R10: `ad_oe_o` is low, and `ad_o` is zero, in every period not named in R3 or R7. This includes the periods in which a fetch or read byte is returned, and all idle time.
- R11: `done_o` pulses for one clock right after the last period of an access, and `rdata_o` is valid from that clock. A write or a kind-3 cycle leaves `rdata_o` unchanged. `req_ready_o` is low while an access runs.
- R12: After reset, `ale_o` and `ad_oe_o` are low, all active-low strobes are high, `done_o` is low, `req_ready_o` is high, and `addr_hi_o` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ea_i | input | 1 | High allows low fetch addresses to use the internal store |
| req_valid_i | input | 1 | Access request present |
| req_ready_o | output | 1 | No access in progress |
| req_kind_i | input | 2 | Access kind (0 fetch, 1 read, 2 write, 3 no-strobe cycle) |
| req_addr_i | input | 16 | Access address |
| req_wdata_i | input | 8 | Byte to write |
| req_short_i | input | 1 | 8-bit indirect data access: high byte from port latch |
| p2_latch_i | input | 8 | Port latch value used as high byte for indirect accesses |
| rdata_o | output | 8 | Last fetched or read byte |
| done_o | output | 1 | One-clock end-of-access pulse |
| osc_tick_o | output | 1 | High on the last clock of each oscillator period |
| rom_addr_o | output | 16 | Address for the internal program store |
| rom_data_i | input | 8 | Internal program store data |
| ale_o | output | 1 | Address latch strobe |
| psen_n_o | output | 1 | Program read strobe, active low |
| rd_n_o | output | 1 | Data read strobe, active low |
| wr_n_o | output | 1 | Data write strobe, active low |
| ad_o | output | 8 | Multiplexed low address / write data |
| ad_oe_o | output | 1 | Drive enable for `ad_o` |
| ad_i | input | 8 | Multiplexed bus input |
| addr_hi_o | output | 8 | High address byte |

## Verification
The bench sets OSC_DIV to 3, so every oscillator period spans several clocks. This shows whether strobe edges move only on the period enable and whether sampling happens on the last clock of a period rather than the first. INT_ROM_BYTES is left at 4096, so the internal/external boundary between addresses 0x0FFF and 0x1000 can be driven directly. The return inputs carry the wanted byte only in the sampling period and the inverse in all other periods, which makes a shifted capture point visible.

// File: rtl/ext_bus_seq_pkg.sv
package ext_bus_seq_pkg;

    localparam int ADDR_W = 16;
    localparam int DATA_W = 8;
    localparam int PH_W   = 4;

    typedef enum logic [1:0] {
        ACC_FETCH = 2'd0,
        ACC_READ  = 2'd1,
        ACC_WRITE = 2'd2,
        ACC_NOP   = 2'd3
    } acc_kind_e;

    // period indices inside an access (period 0 starts at acceptance)
    localparam logic [PH_W-1:0] PH_ALE_LAST   = 4'd1;
    localparam logic [PH_W-1:0] PH_ADR_FIRST  = 4'd1;
    localparam logic [PH_W-1:0] PH_ADR_LAST   = 4'd2;
    localparam logic [PH_W-1:0] PH_PSEN_FIRST = 4'd3;
    localparam logic [PH_W-1:0] PH_PSEN_LAST  = 4'd5;
    localparam logic [PH_W-1:0] PH_WD_FIRST   = 4'd4;
    localparam logic [PH_W-1:0] PH_WD_LAST    = 4'd11;
    localparam logic [PH_W-1:0] PH_STB_FIRST  = 4'd5;
    localparam logic [PH_W-1:0] PH_STB_LAST   = 4'd10;
    localparam logic [PH_W-1:0] PH_FETCH_CAP  = 4'd5;
    localparam logic [PH_W-1:0] PH_READ_CAP   = 4'd10;
    localparam logic [PH_W-1:0] PH_FETCH_LAST = 4'd5;
    localparam logic [PH_W-1:0] PH_DATA_LAST  = 4'd11;

    typedef struct packed {
        acc_kind_e           kind;
        logic                ext;
        logic [ADDR_W-1:0]   addr;
        logic [DATA_W-1:0]   hi;
        logic [DATA_W-1:0]   wdata;
    } acc_t;

    typedef struct packed {
        logic                ale;
        logic                psen_n;
        logic                rd_n;
        logic                wr_n;
        logic                oe;
        logic [DATA_W-1:0]   ad;
    } pins_t;

    function automatic logic [PH_W-1:0] last_phase(acc_kind_e k);
        return (k == ACC_FETCH) ? PH_FETCH_LAST : PH_DATA_LAST;
    endfunction

    function automatic logic captures_at(acc_kind_e k, logic [PH_W-1:0] ph);
        return ((k == ACC_FETCH) && (ph == PH_FETCH_CAP)) ||
               ((k == ACC_READ)  && (ph == PH_READ_CAP));
    endfunction

    function automatic logic in_span(logic [PH_W-1:0] ph,
                                     logic [PH_W-1:0] lo,
                                     logic [PH_W-1:0] hi);
        return (ph >= lo) && (ph <= hi);
    endfunction

    function automatic logic goes_external(acc_kind_e k, logic ea,
                                           logic [ADDR_W-1:0] a,
                                           logic [ADDR_W:0] lim);
        return (k != ACC_FETCH) || !ea || ({1'b0, a} >= lim);
    endfunction

endpackage

// File: rtl/ext_bus_tick_gen.sv
module ext_bus_tick_gen #(
    parameter int OSC_DIV = 2
) (
    input  logic clk,
    input  logic rst,
    output logic tick_o
);
    localparam int CW = (OSC_DIV > 1) ? $clog2(OSC_DIV) : 1;
    localparam logic [CW-1:0] CNT_MAX = CW'(OSC_DIV - 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (cnt_q == CNT_MAX) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign tick_o = (cnt_q == CNT_MAX);

    AST_TICK_PERIODIC: assert property (@(posedge clk) disable iff (rst)
        (tick_o && (OSC_DIV > 1)) |=> !tick_o) else $error("tick repeated"); // R1
endmodule

// File: rtl/ext_bus_seq_ctrl.sv
module ext_bus_seq_ctrl
    import ext_bus_seq_pkg::*;
#(
    parameter int INT_ROM_BYTES = 4096
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                tick_i,
    input  logic                ea_i,
    input  logic                req_valid_i,
    input  logic [1:0]          req_kind_i,
    input  logic [ADDR_W-1:0]   req_addr_i,
    input  logic [DATA_W-1:0]   req_wdata_i,
    input  logic                req_short_i,
    input  logic [DATA_W-1:0]   p2_latch_i,
    input  logic [DATA_W-1:0]   ad_i,
    input  logic [DATA_W-1:0]   rom_data_i,
    output logic                busy_o,
    output logic [PH_W-1:0]     phase_o,
    output acc_t                acc_o,
    output logic                done_o,
    output logic [DATA_W-1:0]   rdata_o
);
    localparam logic [ADDR_W:0] ROM_LIM = INT_ROM_BYTES[ADDR_W:0];

    logic              busy_q;
    logic [PH_W-1:0]   phase_q;
    acc_t              acc_q;
    acc_t              acc_new;
    logic              done_q;
    logic [DATA_W-1:0] rdata_q;

    always_comb begin
        acc_new.kind  = acc_kind_e'(req_kind_i);
        acc_new.ext   = goes_external(acc_kind_e'(req_kind_i), ea_i, req_addr_i, ROM_LIM);
        acc_new.addr  = req_addr_i;
        acc_new.hi    = ((acc_kind_e'(req_kind_i) != ACC_FETCH) && req_short_i)
                        ? p2_latch_i : req_addr_i[ADDR_W-1:ADDR_W-DATA_W];
        acc_new.wdata = req_wdata_i;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q  <= 1'b0;
            phase_q <= '0;
            acc_q   <= '0;
            done_q  <= 1'b0;
            rdata_q <= '0;
        end else begin
            done_q <= 1'b0;
            if (tick_i) begin
                if (busy_q) begin
                    if (captures_at(acc_q.kind, phase_q)) begin
                        rdata_q <= acc_q.ext ? ad_i : rom_data_i;
                    end
                    if (phase_q == last_phase(acc_q.kind)) begin
                        busy_q  <= 1'b0;
                        phase_q <= '0;
                        done_q  <= 1'b1;
                    end else begin
                        phase_q <= phase_q + 4'd1;
                    end
                end else if (req_valid_i) begin
                    busy_q  <= 1'b1;
                    phase_q <= '0;
                    acc_q   <= acc_new;
                end
            end
        end
    end

    assign busy_o  = busy_q;
    assign phase_o = phase_q;
    assign acc_o   = acc_q;
    assign done_o  = done_q;
    assign rdata_o = rdata_q;

    AST_PHASE_HOLD: assert property (@(posedge clk) disable iff (rst)
        (busy_q && !tick_i) |=> $stable(phase_q)) else $error("phase moved off tick"); // R1
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        done_q |=> !done_q) else $error("done longer than one clock"); // R11
    AST_HI_HELD: assert property (@(posedge clk) disable iff (rst)
        (busy_q && $past(busy_q)) |-> $stable(acc_q.hi)) else $error("high byte changed"); // R8
    AST_DONE_ENDS_BUSY: assert property (@(posedge clk) disable iff (rst)
        done_q |-> !busy_q) else $error("done while busy"); // R11
endmodule

// File: rtl/ext_bus_pin_decode.sv
module ext_bus_pin_decode
    import ext_bus_seq_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            busy_i,
    input  logic [PH_W-1:0] phase_i,
    input  acc_t            acc_i,
    output pins_t           pins_o
);
    always_comb begin
        pins_o.ale    = 1'b0;
        pins_o.psen_n = 1'b1;
        pins_o.rd_n   = 1'b1;
        pins_o.wr_n   = 1'b1;
        pins_o.oe     = 1'b0;
        pins_o.ad     = '0;
        if (busy_i && acc_i.ext) begin
            pins_o.ale = (phase_i <= PH_ALE_LAST);
            if (in_span(phase_i, PH_ADR_FIRST, PH_ADR_LAST)) begin
                pins_o.oe = 1'b1;
                pins_o.ad = acc_i.addr[DATA_W-1:0];
            end
            unique case (acc_i.kind)
                ACC_FETCH: begin
                    pins_o.psen_n = !in_span(phase_i, PH_PSEN_FIRST, PH_PSEN_LAST);
                end
                ACC_READ: begin
                    pins_o.rd_n = !in_span(phase_i, PH_STB_FIRST, PH_STB_LAST);
                end
                ACC_WRITE: begin
                    pins_o.wr_n = !in_span(phase_i, PH_STB_FIRST, PH_STB_LAST);
                    if (in_span(phase_i, PH_WD_FIRST, PH_WD_LAST)) begin
                        pins_o.oe = 1'b1;
                        pins_o.ad = acc_i.wdata;
                    end
                end
                default: begin
                end
            endcase
        end
    end

    AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (rst)
        $countones({~pins_o.psen_n, ~pins_o.rd_n, ~pins_o.wr_n}) <= 1) else $error("strobes overlap"); // R6
    AST_ALE_ALONE: assert property (@(posedge clk) disable iff (rst)
        pins_o.ale |-> (pins_o.psen_n && pins_o.rd_n && pins_o.wr_n)) else $error("ale with strobe"); // R2
    AST_FLOAT_ON_READ: assert property (@(posedge clk) disable iff (rst)
        (!pins_o.rd_n || !pins_o.psen_n) |-> !pins_o.oe) else $error("bus driven while returning"); // R10
    AST_WDATA_STABLE: assert property (@(posedge clk) disable iff (rst)
        (!pins_o.wr_n && $past(!pins_o.wr_n)) |-> $stable(pins_o.ad)) else $error("write data moved"); // R7
    AST_PSEN_DATA: assert property (@(posedge clk) disable iff (rst)
        (busy_i && (acc_i.kind != ACC_FETCH)) |-> pins_o.psen_n) else $error("psen on data cycle"); // R4
    AST_INT_QUIET: assert property (@(posedge clk) disable iff (rst)
        (busy_i && !acc_i.ext) |-> (!pins_o.ale && pins_o.psen_n && !pins_o.oe)) else $error("internal fetch on bus"); // R9
endmodule

// File: rtl/ext_bus_seq.sv
module ext_bus_seq
    import ext_bus_seq_pkg::*;
#(
    parameter int OSC_DIV       = 2,
    parameter int INT_ROM_BYTES = 4096
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        ea_i,
    input  logic        req_valid_i,
    output logic        req_ready_o,
    input  logic [1:0]  req_kind_i,
    input  logic [15:0] req_addr_i,
    input  logic [7:0]  req_wdata_i,
    input  logic        req_short_i,
    input  logic [7:0]  p2_latch_i,
    output logic [7:0]  rdata_o,
    output logic        done_o,
    output logic        osc_tick_o,
    output logic [15:0] rom_addr_o,
    input  logic [7:0]  rom_data_i,
    output logic        ale_o,
    output logic        psen_n_o,
    output logic        rd_n_o,
    output logic        wr_n_o,
    output logic [7:0]  ad_o,
    output logic        ad_oe_o,
    input  logic [7:0]  ad_i,
    output logic [7:0]  addr_hi_o
);
    logic            tick;
    logic            busy;
    logic [PH_W-1:0] phase;
    acc_t            acc;
    pins_t           pins;

    ext_bus_tick_gen #(.OSC_DIV(OSC_DIV)) tick_i (
        .clk    (clk),
        .rst    (rst),
        .tick_o (tick)
    );

    ext_bus_seq_ctrl #(.INT_ROM_BYTES(INT_ROM_BYTES)) ctrl_i (
        .clk         (clk),
        .rst         (rst),
        .tick_i      (tick),
        .ea_i        (ea_i),
        .req_valid_i (req_valid_i),
        .req_kind_i  (req_kind_i),
        .req_addr_i  (req_addr_i),
        .req_wdata_i (req_wdata_i),
        .req_short_i (req_short_i),
        .p2_latch_i  (p2_latch_i),
        .ad_i        (ad_i),
        .rom_data_i  (rom_data_i),
        .busy_o      (busy),
        .phase_o     (phase),
        .acc_o       (acc),
        .done_o      (done_o),
        .rdata_o     (rdata_o)
    );

    ext_bus_pin_decode dec_i (
        .clk     (clk),
        .rst     (rst),
        .busy_i  (busy),
        .phase_i (phase),
        .acc_i   (acc),
        .pins_o  (pins)
    );

    assign req_ready_o = !busy;
    assign osc_tick_o  = tick;
    assign rom_addr_o  = acc.addr;
    assign addr_hi_o   = acc.hi;
    assign ale_o       = pins.ale;
    assign psen_n_o    = pins.psen_n;
    assign rd_n_o      = pins.rd_n;
    assign wr_n_o      = pins.wr_n;
    assign ad_o        = pins.ad;
    assign ad_oe_o     = pins.oe;

    AST_IDLE_FLOAT: assert property (@(posedge clk) disable iff (rst)
        req_ready_o |-> (!ad_oe_o && !ale_o && psen_n_o && rd_n_o && wr_n_o)) else $error("bus active while idle"); // R10
    AST_STROBE_ON_TICK: assert property (@(posedge clk) disable iff (rst)
        (!$past(tick) && (OSC_DIV > 1)) |-> ($stable(ale_o) && $stable(rd_n_o) && $stable(wr_n_o) && $stable(psen_n_o))) else $error("strobe moved off period edge"); // R1
endmodule

// File: tb/ext_bus_seq_tb_top.sv
module ext_bus_seq_tb_top;
    localparam int DIV  = 3;
    localparam int ROMB = 4096;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic        rst;
    logic        ea_i, req_valid_i, req_ready_o, req_short_i;
    logic [1:0]  req_kind_i;
    logic [15:0] req_addr_i, rom_addr_o;
    logic [7:0]  req_wdata_i, p2_latch_i, rdata_o, rom_data_i, ad_o, ad_i, addr_hi_o;
    logic        done_o, osc_tick_o, ale_o, psen_n_o, rd_n_o, wr_n_o, ad_oe_o;

    int checks = 0;
    int fails  = 0;
    logic [7:0] exp_rdata = 8'h00;
    bit finished = 0;

    typedef struct packed {
        logic ale, psen_n, rd_n, wr_n, oe;
        logic [7:0] ad;
    } exp_t;

    ext_bus_seq #(.OSC_DIV(DIV), .INT_ROM_BYTES(ROMB)) dut_i (
        .clk(clk), .rst(rst), .ea_i(ea_i), .req_valid_i(req_valid_i),
        .req_ready_o(req_ready_o), .req_kind_i(req_kind_i), .req_addr_i(req_addr_i),
        .req_wdata_i(req_wdata_i), .req_short_i(req_short_i), .p2_latch_i(p2_latch_i),
        .rdata_o(rdata_o), .done_o(done_o), .osc_tick_o(osc_tick_o),
        .rom_addr_o(rom_addr_o), .rom_data_i(rom_data_i), .ale_o(ale_o),
        .psen_n_o(psen_n_o), .rd_n_o(rd_n_o), .wr_n_o(wr_n_o), .ad_o(ad_o),
        .ad_oe_o(ad_oe_o), .ad_i(ad_i), .addr_hi_o(addr_hi_o)
    );

    task automatic chk(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h t=%0t", req, what, act, exp, $time);
        end
    endtask

    function automatic exp_t expect_pins(int kind, bit ext, logic [15:0] a, logic [7:0] wd, int p);
        exp_t e;
        e = '{ale:1'b0, psen_n:1'b1, rd_n:1'b1, wr_n:1'b1, oe:1'b0, ad:8'h00};
        if (ext) begin
            if (p < 2) e.ale = 1'b1;
            if (p == 1 || p == 2) begin e.oe = 1'b1; e.ad = a[7:0]; end
            if (kind == 0 && p >= 3 && p <= 5)  e.psen_n = 1'b0;
            if (kind == 1 && p >= 5 && p <= 10) e.rd_n = 1'b0;
            if (kind == 2 && p >= 5 && p <= 10) e.wr_n = 1'b0;
            if (kind == 2 && p >= 4 && p <= 11) begin e.oe = 1'b1; e.ad = wd; end
        end
        return e;
    endfunction

    task automatic run_access(int kind, logic [15:0] a, logic [7:0] wd, bit shrt,
                              logic [7:0] p2, logic [7:0] ret);
        bit ext;
        int last, cap, guard;
        logic [7:0] hi;
        exp_t e;
        string ad_req;
        ext  = (kind != 0) || !ea_i || (a >= 16'(ROMB));
        last = (kind == 0) ? 5 : 11;
        cap  = (kind == 0) ? 5 : ((kind == 1) ? 10 : -1);
        hi   = (kind != 0 && shrt) ? p2 : a[15:8];
        @(negedge clk);
        req_valid_i = 1'b1; req_kind_i = 2'(kind); req_addr_i = a;
        req_wdata_i = wd; req_short_i = shrt; p2_latch_i = p2;
        ad_i = ~ret; rom_data_i = ~ret;
        guard = 0;
        while (!(req_ready_o && osc_tick_o) && guard < 100) begin
            @(negedge clk);
            guard++;
        end
        chk(guard < 100, "R1", "accept wait", 32'(guard), 32'd0);
        for (int n = 0; n < (last + 1) * DIV; n++) begin
            int p;
            @(negedge clk);
            p = n / DIV;
            if (n == 0) begin
                req_valid_i = 1'b0; req_addr_i = ~a; req_wdata_i = ~wd; p2_latch_i = ~p2;
            end
            if (ext) ad_i = (p == cap) ? ret : ~ret;
            else rom_data_i = (p == cap) ? ret : ~ret;
            e = expect_pins(kind, ext, a, wd, p);
            chk(ale_o == e.ale, "R2", "ale", 32'(ale_o), 32'(e.ale));
            chk(psen_n_o == e.psen_n, ext ? "R4" : "R9", "psen_n", 32'(psen_n_o), 32'(e.psen_n));
            chk({rd_n_o, wr_n_o} == {e.rd_n, e.wr_n}, "R6", "rd_n/wr_n",
                32'({rd_n_o, wr_n_o}), 32'({e.rd_n, e.wr_n}));
            ad_req = (p == 1 || p == 2) ? "R3" : ((kind == 2 && p >= 4) ? "R7" : "R10");
            if (!ext) ad_req = "R9";
            chk({ad_oe_o, ad_o} == {e.oe, e.ad}, ad_req, "oe/ad",
                32'({ad_oe_o, ad_o}), 32'({e.oe, e.ad}));
            chk(addr_hi_o == hi, "R8", "addr_hi", 32'(addr_hi_o), 32'(hi));
            chk(!req_ready_o && !done_o, "R11", "ready/done during access",
                32'({req_ready_o, done_o}), 32'd0);
            if (!ext) chk(rom_addr_o == a, "R9", "rom_addr", 32'(rom_addr_o), 32'(a));
        end
        @(negedge clk);
        if (kind == 0 || kind == 1) exp_rdata = ret;
        chk(done_o == 1'b1, "R1", "done after last period", 32'(done_o), 32'd1);
        chk(rdata_o == exp_rdata, (kind == 0) ? ((ext) ? "R5" : "R9") : "R5",
            "rdata", 32'(rdata_o), 32'(exp_rdata));
        chk(req_ready_o == 1'b1, "R11", "ready after end", 32'(req_ready_o), 32'd1);
        @(negedge clk);
        chk(done_o == 1'b0, "R11", "done one clock", 32'(done_o), 32'd0);
        chk(!ad_oe_o && !ale_o && psen_n_o && rd_n_o && wr_n_o, "R10", "idle bus",
            32'({ad_oe_o, ale_o, psen_n_o, rd_n_o, wr_n_o}), 32'b00111);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            fails++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd7741));
        rst = 1'b1; ea_i = 1'b1; req_valid_i = 1'b0; req_kind_i = 2'd0;
        req_addr_i = 16'h0; req_wdata_i = 8'h0; req_short_i = 1'b0;
        p2_latch_i = 8'h0; rom_data_i = 8'h0; ad_i = 8'h0;
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R12 reset state
        chk(!ale_o && !ad_oe_o && psen_n_o && rd_n_o && wr_n_o, "R12", "strobes after reset",
            32'({ale_o, ad_oe_o, psen_n_o, rd_n_o, wr_n_o}), 32'b00111);
        chk(!done_o && req_ready_o && addr_hi_o == 8'h00, "R12", "done/ready/hi after reset",
            32'({done_o, req_ready_o, addr_hi_o}), 32'h100);
        // R1 period spacing of the tick
        begin
            int seen = 0;
            int gap = 0;
            int gaps_ok = 1;
            for (int k = 0; k < 4 * DIV; k++) begin
                @(negedge clk);
                if (osc_tick_o) begin
                    if (seen > 0 && gap != DIV) gaps_ok = 0;
                    seen++; gap = 1;
                end else gap++;
            end
            chk(gaps_ok == 1 && seen >= 3, "R1", "tick spacing", 32'(seen), 32'd4);
        end
        // R9 boundary: last internal address and first external one
        ea_i = 1'b1;
        run_access(0, 16'h0FFF, 8'h00, 1'b0, 8'h00, 8'h5A);
        run_access(0, 16'h1000, 8'h00, 1'b0, 8'h00, 8'hC3);
        ea_i = 1'b0;
        run_access(0, 16'h0010, 8'h00, 1'b0, 8'h00, 8'h96);
        ea_i = 1'b1;
        run_access(1, 16'h8034, 8'h00, 1'b0, 8'h11, 8'h3E);
        run_access(2, 16'h1234, 8'hA5, 1'b1, 8'h77, 8'h00);
        run_access(1, 16'hABCD, 8'h00, 1'b1, 8'h3C, 8'h81);
        run_access(3, 16'h4455, 8'h66, 1'b0, 8'h00, 8'h99);
        run_access(0, 16'h0000, 8'h00, 1'b0, 8'h00, 8'h0F);
        for (int i = 0; i < 40; i++) begin
            int kind;
            logic [15:0] a;
            kind = int'($urandom_range(3, 0));
            a = 16'($urandom());
            if ($urandom_range(1, 0) == 0) a[15:12] = 4'h0;
            ea_i = 1'($urandom_range(1, 0));
            run_access(kind, a, 8'($urandom()), 1'($urandom_range(1, 0)),
                       8'($urandom()), 8'($urandom()));
        end
        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule